// File: doc/BRIEF.md
# Trace-Buffered Stride Prediction Updater

This block is the retire-side update path of a value predictor that keeps no PC-indexed table. Every prediction trace that leaves the front end carries one group of prediction fields for each of its instruction slots: the predicted result, a predicting stride, a 2-bit confidence and, in the default two-delta mode, a last-seen stride. When a trace is renamed, the block pushes it into a small in-order queue. When the matching retired trace arrives with its actual results, the block pops the oldest queued trace. It compares each slot's prediction with the real result and produces a refreshed prediction trace. That trace is meant to be written back into the prediction value cache.

All predictor state lives in the queued traces. Every accepted retirement yields exactly one new trace, registered one clock later, with a per-slot hit flag and a per-slot permission to speculate. A per-slot mask from retirement marks the real, result-producing, correct-path slots. Any slot not marked is carried through untouched, except that its confidence is cleared.

Top module: `stride_trace_updater`

## Requirements
- R1: Traces leave the queue in push order. A push is accepted when `push_valid` is high and `q_full` is low. Slot i sits at bits [i*SW +: SW] with SW = 66. Inside a slot, bits [31:0] are the value, [33:32] the confidence, [49:34] the predicting stride and [65:50] the last-seen stride.
- R2: `q_full` is high exactly when 32 traces are queued. A push while full is dropped, and the queue content is unchanged.
- R3: A retirement while the queue is empty is ignored: no output trace, and the queue stays empty.
- R4: A retirement accepted at one clock edge raises `out_valid` for one cycle after that edge, with the refreshed oldest trace. At all other times `out_valid` is low.
- R5: For a masked slot, hit means the actual result equals the predicted value. The confidence rises by 1 on a hit and falls by 1 on a miss, saturating at 3 and 0. `out_hit` reports the per-slot comparison.
- R6: For a masked slot, the new value is the actual result plus the new predicting stride, sign-extended from 16 bits, modulo 2^32.
- R7: The observed difference is the actual result minus (old value minus sign-extended old predicting stride), truncated to 16 bits. It becomes the new last-seen stride. The predicting stride takes the difference only when the difference equals the old last-seen stride; otherwise the predicting stride is kept.
- R8: An unmasked (invalid or wrong-path) slot keeps its value and both strides, gets confidence 0, and reports hit 0 and speculate 0.
- R9: `out_spec` for a slot is high exactly when its new confidence is greater than 2.
- R10: After reset, `q_empty` is 1, and `q_full` and `out_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_valid | input | 1 | Renamed trace is offered to the queue |
| push_trace | input | SLOTS*SW | Prediction trace to queue |
| q_full | output | 1 | Queue holds DEPTH traces; pushes are dropped |
| retire_valid | input | 1 | Retired trace results are present |
| retire_results | input | SLOTS*VAL_W | Actual result per slot |
| retire_mask | input | SLOTS | Slot is a real, correct-path, result-producing instruction |
| q_empty | output | 1 | Queue holds no trace |
| out_valid | output | 1 | Refreshed prediction trace is present |
| out_trace | output | SLOTS*SW | Refreshed prediction trace |
| out_hit | output | SLOTS | Per-slot prediction matched |
| out_spec | output | SLOTS | Per-slot confidence now permits speculation |

## Verification
The bound checker watches the queue and output handshake on every cycle: full and empty never coexist, pushes and pops on a full or empty queue behave as required, and an output follows exactly the retirements that found a trace. It also checks that no speculation flag appears without a hit, and that unmasked slots never report a hit. The arithmetic of the per-slot update is shown only by the bench's scenarios. Those cover saturation of confidence at both ends, the two-delta stride swap against the keep case, and ordering across a full queue. The bench compares them field by field against its behavioural model.

// File: rtl/stu_pkg.sv
// Shared constants and helpers for the trace-buffered stride updater.
package stu_pkg;
    localparam int unsigned CONF_W = 2;
    localparam logic [CONF_W-1:0] CONF_MAX   = '1;
    localparam logic [CONF_W-1:0] CONF_MIN   = '0;
    localparam logic [CONF_W-1:0] SPEC_ABOVE = 2'd2;

    // Saturating one-step move of a confidence counter.
    function automatic logic [CONF_W-1:0] conf_step(input logic [CONF_W-1:0] c,
                                                    input logic up);
        logic [CONF_W-1:0] r;
        if (up) r = (c == CONF_MAX) ? c : c + 1'b1;
        else    r = (c == CONF_MIN) ? c : c - 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/stu_trace_queue.sv
// In-order trace queue with one write and one read port.
// Assumes: the caller only presents data; the queue itself drops pushes
// when full and pops when empty. Read data is the oldest entry, combinational.
module stu_trace_queue #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_req,
    output logic [WIDTH-1:0] rd_data,
    output logic             wr_ok,
    output logic             rd_ok,
    output logic             full,
    output logic             empty
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] level;

    // Accept decisions are taken from the state before this edge.
    always_comb begin
        full  = (level == CNT_W'(DEPTH));
        empty = (level == '0);
        wr_ok = wr_req && !full;
        rd_ok = rd_req && !empty;
        rd_data = store[rd_ptr];
    end

    // Write the storage array on an accepted push.
    always_ff @(posedge clk) begin
        if (wr_ok) store[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/stu_slot_update.sv
// Per-slot stride and confidence refresh.
// Assumes: VAL_W > STRIDE_W. Slot layout from low bits: value, confidence,
// predicting stride, then (two-delta only) last-seen stride.
module stu_slot_update
    import stu_pkg::*;
#(
    parameter int unsigned VAL_W     = 32,
    parameter int unsigned STRIDE_W  = 16,
    parameter bit          TWO_DELTA = 1'b1,
    parameter int unsigned SW        = VAL_W + CONF_W + STRIDE_W * (TWO_DELTA ? 2 : 1)
) (
    input  logic [SW-1:0]    slot_in,
    input  logic [VAL_W-1:0] actual,
    input  logic             live,
    output logic [SW-1:0]    slot_out,
    output logic             hit,
    output logic             spec
);
    localparam int unsigned CONF_LSB = VAL_W;
    localparam int unsigned PRED_LSB = VAL_W + CONF_W;
    localparam int unsigned CORE_W   = PRED_LSB + STRIDE_W;
    localparam int unsigned EXT_W    = VAL_W - STRIDE_W;

    logic [VAL_W-1:0]    old_val, prev_act, diff_full, new_val;
    logic [CONF_W-1:0]   old_conf, new_conf;
    logic [STRIDE_W-1:0] old_pred, diff, new_pred;
    logic [CORE_W-1:0]   core_out;

    // Observed difference against the result implied by the old prediction.
    always_comb begin
        old_val   = slot_in[VAL_W-1:0];
        old_conf  = slot_in[CONF_LSB +: CONF_W];
        old_pred  = slot_in[PRED_LSB +: STRIDE_W];
        prev_act  = old_val - {{EXT_W{old_pred[STRIDE_W-1]}}, old_pred};
        diff_full = actual - prev_act;
        diff      = diff_full[STRIDE_W-1:0];
    end

    generate
        if (TWO_DELTA) begin : g_two_delta
            logic [STRIDE_W-1:0] old_last;
            // Predicting stride moves only when the difference repeats.
            always_comb begin
                old_last = slot_in[CORE_W +: STRIDE_W];
                new_pred = (diff == old_last) ? diff : old_pred;
            end
            assign slot_out = {(live ? diff : old_last), core_out};
        end else begin : g_basic
            // Basic stride follows the last difference directly.
            always_comb new_pred = diff;
            assign slot_out = core_out;
        end
    endgenerate

    // Confidence, next value and flags for the slot.
    always_comb begin
        hit      = live && (actual == old_val);
        new_conf = live ? conf_step(old_conf, hit) : CONF_MIN;
        new_val  = actual + {{EXT_W{new_pred[STRIDE_W-1]}}, new_pred};
        spec     = new_conf > SPEC_ABOVE;
        if (live) core_out = {new_pred, new_conf, new_val};
        else      core_out = {old_pred, new_conf, old_val};
    end
endmodule

// File: rtl/stride_trace_updater.sv
// Top: queues renamed prediction traces and, on each retirement, refreshes
// the oldest one into a new prediction trace registered one cycle later.
// Assumes: retirements arrive in trace order; retire_mask already excludes
// wrong-path and non-result slots.
module stride_trace_updater
    import stu_pkg::*;
#(
    parameter int unsigned SLOTS     = 16,
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned VAL_W     = 32,
    parameter int unsigned STRIDE_W  = 16,
    parameter bit          TWO_DELTA = 1'b1,
    parameter int unsigned SW        = VAL_W + CONF_W + STRIDE_W * (TWO_DELTA ? 2 : 1),
    parameter int unsigned TW        = SLOTS * SW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_valid,
    input  logic [TW-1:0]          push_trace,
    output logic                   q_full,
    input  logic                   retire_valid,
    input  logic [SLOTS*VAL_W-1:0] retire_results,
    input  logic [SLOTS-1:0]       retire_mask,
    output logic                   q_empty,
    output logic                   out_valid,
    output logic [TW-1:0]          out_trace,
    output logic [SLOTS-1:0]       out_hit,
    output logic [SLOTS-1:0]       out_spec
);
    logic [TW-1:0]    head_trace, next_trace;
    logic [SLOTS-1:0] next_hit, next_spec;
    logic             push_ok, pop_ok;

    stu_trace_queue #(.DEPTH(DEPTH), .WIDTH(TW)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (push_valid),
        .wr_data (push_trace),
        .rd_req  (retire_valid),
        .rd_data (head_trace),
        .wr_ok   (push_ok),
        .rd_ok   (pop_ok),
        .full    (q_full),
        .empty   (q_empty)
    );

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            stu_slot_update #(
                .VAL_W(VAL_W), .STRIDE_W(STRIDE_W), .TWO_DELTA(TWO_DELTA), .SW(SW)
            ) u_slot (
                .slot_in  (head_trace[s*SW +: SW]),
                .actual   (retire_results[s*VAL_W +: VAL_W]),
                .live     (retire_mask[s]),
                .slot_out (next_trace[s*SW +: SW]),
                .hit      (next_hit[s]),
                .spec     (next_spec[s])
            );
        end
    endgenerate

    // Register the refreshed trace for one cycle per accepted retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_trace <= '0;
            out_hit   <= '0;
            out_spec  <= '0;
        end else begin
            out_valid <= pop_ok;
            if (pop_ok) begin
                out_trace <= next_trace;
                out_hit   <= next_hit;
                out_spec  <= next_spec;
            end
        end
    end

    logic unused_push_ok;
    assign unused_push_ok = push_ok;
endmodule

// File: rtl/stu_checker.sv
// Cycle-level protocol checks for stride_trace_updater, attached by bind.
module stu_checker #(
    parameter int unsigned SLOTS = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             retire_valid,
    input logic [SLOTS-1:0] retire_mask,
    input logic             q_full,
    input logic             q_empty,
    input logic             out_valid,
    input logic [SLOTS-1:0] out_hit,
    input logic [SLOTS-1:0] out_spec
);
    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_full && q_empty));
    // R2
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_full && !retire_valid |=> q_full);
    // R1
    push_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty && push_valid |=> !q_empty);
    // R3
    empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty && retire_valid |=> !out_valid);
    // R3
    empty_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_empty && !push_valid |=> q_empty);
    // R4
    pop_gives_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid && !q_empty |=> out_valid);
    // R4
    no_spurious_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !retire_valid |=> !out_valid);
    // R9
    spec_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_spec & ~out_hit) == '0));
    // R8
    masked_out_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid && !q_empty |=> ((out_hit & ~$past(retire_mask)) == '0));
endmodule

bind stride_trace_updater stu_checker #(.SLOTS(SLOTS)) u_stu_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_valid   (push_valid),
    .retire_valid (retire_valid),
    .retire_mask  (retire_mask),
    .q_full       (q_full),
    .q_empty      (q_empty),
    .out_valid    (out_valid),
    .out_hit      (out_hit),
    .out_spec     (out_spec)
);

// File: tb/tb_stride_trace_updater.sv
module tb_stride_trace_updater;
    localparam int SLOTS = 16;
    localparam int DEPTH = 32;
    localparam int SW    = 66;
    localparam int TW    = SLOTS * SW;
    localparam int VW    = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0, retire_valid = 1'b0;
    logic [TW-1:0] push_trace = '0;
    logic [SLOTS*VW-1:0] retire_results = '0;
    logic [SLOTS-1:0] retire_mask = '0;
    logic q_full, q_empty, out_valid;
    logic [TW-1:0] out_trace;
    logic [SLOTS-1:0] out_hit, out_spec;

    always #5 clk = ~clk;

    stride_trace_updater dut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_trace(push_trace),
        .q_full(q_full), .retire_valid(retire_valid), .retire_results(retire_results),
        .retire_mask(retire_mask), .q_empty(q_empty), .out_valid(out_valid),
        .out_trace(out_trace), .out_hit(out_hit), .out_spec(out_spec)
    );

    int checks = 0, errors = 0;
    logic [TW-1:0] mq[$];
    logic exp_valid = 1'b0;
    logic [TW-1:0] exp_trace = '0;
    logic [SLOTS-1:0] exp_hit = '0, exp_spec = '0, exp_mask = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic longint sx16(input longint x);
        return (x >= 32768) ? x - 65536 : x;
    endfunction

    // Behavioural refresh of one trace.
    function automatic void model_refresh(input logic [TW-1:0] t, input logic [SLOTS*VW-1:0] a,
                                          input logic [SLOTS-1:0] m, output logic [TW-1:0] r,
                                          output logic [SLOTS-1:0] h, output logic [SLOTS-1:0] sp);
        r = t; h = '0; sp = '0;
        for (int s = 0; s < SLOTS; s++) begin
            longint v  = longint'(t[s*SW +: 32]);
            int     c  = int'(t[s*SW+32 +: 2]);
            longint ps = longint'(t[s*SW+34 +: 16]);
            longint ls = longint'(t[s*SW+50 +: 16]);
            longint av = longint'(a[s*VW +: 32]);
            if (m[s]) begin
                longint prev, d;
                h[s] = (av == v);
                c = h[s] ? ((c < 3) ? c + 1 : 3) : ((c > 0) ? c - 1 : 0);
                prev = (v - sx16(ps)) & 64'hFFFF_FFFF;
                d = (av - prev) & 64'hFFFF;
                if (d == ls) ps = d;
                ls = d;
                v = (av + sx16(ps)) & 64'hFFFF_FFFF;
                sp[s] = (c > 2);
            end else c = 0;
            r[s*SW +: SW] = {16'(ls), 16'(ps), 2'(c), 32'(v)};
        end
    endfunction

    // One clock: model follows the edge, outputs compared at the falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            mq.delete(); exp_valid = 1'b0;
        end else begin
            exp_valid = retire_valid && (mq.size() > 0);
            if (exp_valid) begin
                model_refresh(mq[0], retire_results, retire_mask, exp_trace, exp_hit, exp_spec);
                exp_mask = retire_mask;
            end
            if (push_valid && mq.size() < DEPTH) mq.push_back(push_trace);
            if (exp_valid) void'(mq.pop_front());
        end
        @(negedge clk);
        chk("R2 q_full", 64'(q_full), 64'(mq.size() == DEPTH));
        chk("R3 q_empty", 64'(q_empty), 64'(mq.size() == 0));
        chk("R4 out_valid", 64'(out_valid), 64'(exp_valid));
        if (exp_valid && out_valid) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (!exp_mask[s]) chk("R8 unmasked slot", 64'(out_trace[s*SW +: SW]), 64'(exp_trace[s*SW +: SW]));
                chk("R6 value", 64'(out_trace[s*SW +: 32]), 64'(exp_trace[s*SW +: 32]));
                chk("R5 confidence", 64'(out_trace[s*SW+32 +: 2]), 64'(exp_trace[s*SW+32 +: 2]));
                chk("R7 strides", 64'(out_trace[s*SW+34 +: 32]), 64'(exp_trace[s*SW+34 +: 32]));
            end
            chk("R5 hit", 64'(out_hit), 64'(exp_hit));
            chk("R9 spec", 64'(out_spec), 64'(exp_spec));
            chk("R1 order", 64'(out_trace == exp_trace), 64'd1);
        end
    endtask

    function automatic logic [TW-1:0] make_trace();
        logic [TW-1:0] t;
        for (int s = 0; s < SLOTS; s++) begin
            logic [15:0] ps = 16'($urandom_range(0, 40)) - 16'd20;
            logic [15:0] ls = ($urandom_range(0, 1) == 0) ? ps : 16'($urandom_range(0, 40)) - 16'd20;
            t[s*SW +: SW] = {ls, ps, 2'($urandom_range(0, 3)), 32'($urandom)};
        end
        return t;
    endfunction

    // Actual results aimed at hits, repeated differences or misses.
    function automatic logic [SLOTS*VW-1:0] make_results(input logic [TW-1:0] t);
        logic [SLOTS*VW-1:0] a;
        for (int s = 0; s < SLOTS; s++) begin
            logic [31:0] v = t[s*SW +: 32];
            logic [31:0] ps = {{16{t[s*SW+49]}}, t[s*SW+34 +: 16]};
            logic [31:0] ls = {{16{t[s*SW+65]}}, t[s*SW+50 +: 16]};
            case ($urandom_range(0, 2))
                0: a[s*VW +: VW] = v;
                1: a[s*VW +: VW] = v - ps + ls;
                default: a[s*VW +: VW] = v + 32'($urandom_range(1, 9));
            endcase
        end
        return a;
    endfunction

    task automatic retire_front(input logic [SLOTS-1:0] m);
        retire_valid = 1'b1;
        retire_mask = m;
        retire_results = (mq.size() > 0) ? make_results(mq[0]) : '0;
    endtask

    task automatic run_all();
        void'($urandom(7));
        repeat (3) step();
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 empty after reset", 64'(q_empty), 64'd1);
        chk("R10 not full after reset", 64'(q_full), 64'd0);
        chk("R10 no output after reset", 64'(out_valid), 64'd0);
        // R3: retire while empty
        retire_front('1); step(); retire_valid = 1'b0; step();
        // R2: fill to capacity, then one extra push that must be dropped
        for (int i = 0; i < DEPTH + 1; i++) begin
            push_valid = 1'b1; push_trace = make_trace(); step();
        end
        push_valid = 1'b0;
        // R8: all-masked, none-masked and mixed retirements while draining
        retire_front('1); step();
        retire_front('0); step();
        for (int i = 0; i < DEPTH; i++) begin
            retire_front(SLOTS'($urandom)); step();
        end
        retire_valid = 1'b0; step();
        // Mixed traffic with simultaneous push and retire
        for (int i = 0; i < 3000; i++) begin
            push_valid = ($urandom_range(0, 9) < 6);
            push_trace = make_trace();
            if ($urandom_range(0, 9) < 5) retire_front(SLOTS'($urandom));
            else retire_valid = 1'b0;
            step();
        end
        push_valid = 1'b0; retire_valid = 1'b0; step();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule